// File: doc/BRIEF.md
# VLIW Bundle Slot Allocator

This block sits between the bundle fetch stage and one ALU group made of four general lanes and one special lane for transcendental functions. Each cycle it can accept one packed bundle of one to five scalar operations. It assigns every operation to a lane and holds the bundle until every lane has been issued. A lane issues only when its source operands fit into the register-file read ports available in that cycle.

Lane assignment follows a fixed order. Transcendental-only operations go straight to the special lane. Dot-product components use general lanes only, so a short dot product takes only as many lanes as it has components. Generic operations fill the remaining general lanes and move to the special lane only when all four general lanes are taken. The special lane has no read ports of its own. It can read an operand for free when an issuing general lane reads the same register in that cycle. Otherwise it has to wait for ports left over after the general lanes. Each operation's 64-bit word, its source addresses and the bundle's two 64-bit literals are passed through unchanged to the lanes when they issue.

Top module: `vba_alloc`

## Requirements
- R1: After reset, no lane issues, `stall_o` is low and `err_o` is low until a valid bundle is accepted.
- R2: A bundle carries `bnd_cnt_i` operations (1 to 5) in slots 0..cnt-1, each with a 2-bit class: 00 generic, 01 special-only, 10 general-only (dot-product component), 11 illegal. Generic operations take the general lanes 0..3 in slot order, after the general-only operations. Only when all four general lanes are taken does a generic operation go to lane 4, the special lane.
- R3: A special-only operation is always placed on lane 4.
- R4: General-only operations are placed on general lanes, in slot order, before any generic operation. A dot product of n<4 components therefore leaves 4-n general lanes free for the other operations in the same bundle.
- R5: A bundle is dropped, and `err_o` is high for the one cycle after it is taken, if any of these holds: the count is 0 or above 5, it contains more than one special-only operation, it contains five general-only operations, or any class is 11. No lane issues from a dropped bundle.
- R6: Within one cycle, identical register addresses read by issuing lanes count as a single read port. The number of distinct addresses read by all issuing lanes never exceeds `RD_PORTS`.
- R7: General lanes compete for ports in lane order 0..3. A lane whose new addresses do not fit waits. A later lane that does fit still issues in that cycle.
- R8: The special lane is considered last. It issues when every source it reads is either read by a general lane issuing in the same cycle or fits in the ports those lanes leave free. Otherwise it waits.
- R9: While any lane of the held bundle stays unissued after the current cycle, `stall_o` is high and a presented bundle is ignored. A lane is issued at most once per bundle.
- R10: When `alu_rdy_i` is low, no lane issues and the held bundle is kept.
- R11: An issuing lane presents its operation word, source addresses and source valid bits unchanged, and `lane_lit_o` carries the bundle's two literals unchanged.
- R12: A bundle taken at a clock edge can issue from the next cycle on. `stall_o` falls in the cycle in which the last lanes issue, so the next bundle is taken at that edge without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_valid_i | input | 1 | A bundle is presented |
| bnd_cnt_i | input | 3 | Number of operations in the bundle |
| bnd_cls_i | input | 5x2 | Class code per slot |
| bnd_op_i | input | 5x64 | Operation word per slot |
| bnd_src_i | input | 5x3x10 | Source register addresses per slot |
| bnd_srcv_i | input | 5x3 | Source address valid bits per slot |
| bnd_lit_i | input | 2x64 | Literal constants of the bundle |
| alu_rdy_i | input | 1 | ALU group can accept issues this cycle |
| stall_o | output | 1 | Held bundle not finished, fetch must wait |
| err_o | output | 1 | Previous bundle was illegal and dropped |
| lane_issue_o | output | 5 | Issue strobe per lane, lane 4 is the special lane |
| lane_op_o | output | 5x64 | Operation word per lane |
| lane_src_o | output | 5x3x10 | Operand read addresses per lane |
| lane_srcv_o | output | 5x3 | Operand address valid bits per lane |
| lane_lit_o | output | 2x64 | Literals forwarded with the issued lanes |

## Verification
A wrong lane map shows up in the first issue cycle after a bundle is taken, as an operation word on the wrong lane or a strobe on the wrong lane. A corrupted pending mask shows up as a lane issued twice, a lane never issued, or a `stall_o` value that disagrees with the remaining lanes, all within the same cycle the mask is used. A port-count error shows up as a lane issuing a cycle early or late relative to its share of the read budget. The reference model therefore compares the strobes, stall, error flag and forwarded data on every clock, so any of these faults is reported in the cycle it first reaches the ports.

// File: rtl/vba_pkg.sv
// Shared lane geometry and operation class codes for the bundle slot allocator.
// Assumes one ALU group: NGEN general lanes plus one special lane at index NGEN.
package vba_pkg;
    localparam int NGEN  = 4;                 // general lanes per group
    localparam int NLANE = NGEN + 1;          // general lanes plus special lane
    localparam int SPEC  = NGEN;              // index of the special lane
    localparam int NSRC  = 3;                 // source operands per operation
    localparam int CNTW  = $clog2(NLANE + 2); // count field, room for illegal counts
    localparam int LW    = $clog2(NLANE + 1); // lane cursor width

    typedef enum logic [1:0] {
        CLS_ANY  = 2'b00,   // any lane may execute
        CLS_SPEC = 2'b01,   // transcendental, special lane only
        CLS_GEN  = 2'b10,   // dot-product component, general lanes only
        CLS_BAD  = 2'b11    // illegal code
    } op_cls_e;
endpackage

// File: rtl/vba_slot_map.sv
// Combinational lane mapper: turns an incoming bundle into a per-lane view.
// Places general-only ops first, then generic ops, spilling the fifth generic
// op onto the special lane; special-only ops always land on the special lane.
// Assumes slots at or above the count carry no meaning.
module vba_slot_map
    import vba_pkg::*;
#(
    parameter int OPW = 64,
    parameter int AW  = 10
) (
    input  logic [CNTW-1:0]                     cnt_i,
    input  logic [NLANE-1:0][1:0]               cls_i,
    input  logic [NLANE-1:0][OPW-1:0]           op_i,
    input  logic [NLANE-1:0][NSRC-1:0][AW-1:0]  src_i,
    input  logic [NLANE-1:0][NSRC-1:0]          srcv_i,
    output logic                                bad_o,
    output logic [NLANE-1:0]                    mask_o,
    output logic [NLANE-1:0][OPW-1:0]           op_o,
    output logic [NLANE-1:0][NSRC-1:0][AW-1:0]  src_o,
    output logic [NLANE-1:0][NSRC-1:0]          srcv_o
);
    int        n_spec;
    int        n_gen;
    logic [LW-1:0] slot;
    op_cls_e   want;

    // Validate the bundle and build the lane view in placement order.
    always_comb begin
        bad_o  = (cnt_i == '0) || (int'(cnt_i) > NLANE);
        mask_o = '0;
        op_o   = '0;
        src_o  = '0;
        srcv_o = '0;
        n_spec = 0;
        n_gen  = 0;
        slot   = '0;
        want   = CLS_ANY;
        for (int i = 0; i < NLANE; i++) begin
            if (i < int'(cnt_i)) begin
                if (op_cls_e'(cls_i[i]) == CLS_BAD)  bad_o = 1'b1;
                if (op_cls_e'(cls_i[i]) == CLS_SPEC) n_spec++;
                if (op_cls_e'(cls_i[i]) == CLS_GEN)  n_gen++;
            end
        end
        if (n_spec > 1 || n_gen > NGEN) bad_o = 1'b1;
        for (int pass = 0; pass < 2; pass++) begin
            want = (pass == 0) ? CLS_GEN : CLS_ANY;
            for (int i = 0; i < NLANE; i++) begin
                if (i < int'(cnt_i) && op_cls_e'(cls_i[i]) == want && int'(slot) < NLANE) begin
                    mask_o[slot] = 1'b1;
                    op_o[slot]   = op_i[i];
                    src_o[slot]  = src_i[i];
                    srcv_o[slot] = srcv_i[i];
                    slot         = slot + 1'b1;
                end
            end
        end
        for (int i = 0; i < NLANE; i++) begin
            if (i < int'(cnt_i) && op_cls_e'(cls_i[i]) == CLS_SPEC) begin
                mask_o[SPEC] = 1'b1;
                op_o[SPEC]   = op_i[i];
                src_o[SPEC]  = src_i[i];
                srcv_o[SPEC] = srcv_i[i];
            end
        end
    end
endmodule

// File: rtl/vba_port_arb.sv
// Combinational read-port arbiter for the held bundle.
// General lanes are tried in lane order, the special lane last. A source costs
// a port only if no lane already granted this cycle reads the same address and
// no earlier source of the same lane repeats it. Assumes RD_PORTS >= NSRC so a
// lone lane always fits.
module vba_port_arb
    import vba_pkg::*;
#(
    parameter int AW       = 10,
    parameter int RD_PORTS = 8
) (
    input  logic                                rdy_i,
    input  logic [NLANE-1:0]                    pend_i,
    input  logic [NLANE-1:0][NSRC-1:0][AW-1:0]  src_i,
    input  logic [NLANE-1:0][NSRC-1:0]          srcv_i,
    output logic [NLANE-1:0]                    grant_o
);
    logic [NLANE-1:0] g;
    int               used;
    int               need;
    logic             hit;

    // Walk lanes in priority order, charging only addresses not yet read.
    always_comb begin
        g    = '0;
        used = 0;
        need = 0;
        hit  = 1'b0;
        for (int l = 0; l < NLANE; l++) begin
            need = 0;
            for (int s = 0; s < NSRC; s++) begin
                hit = 1'b0;
                for (int j = 0; j < NGEN; j++) begin
                    for (int t = 0; t < NSRC; t++) begin
                        if (j < l && g[j] && srcv_i[j][t] && src_i[j][t] == src_i[l][s]) hit = 1'b1;
                    end
                end
                for (int t = 0; t < NSRC; t++) begin
                    if (t < s && srcv_i[l][t] && src_i[l][t] == src_i[l][s]) hit = 1'b1;
                end
                if (srcv_i[l][s] && !hit) need++;
            end
            if (rdy_i && pend_i[l] && (used + need) <= RD_PORTS) begin
                g[l] = 1'b1;
                used = used + need;
            end
        end
        grant_o = g;
    end
endmodule

// File: rtl/vba_alloc.sv
// Bundle slot allocator top: takes one bundle when not stalled, holds its lane
// view and pending mask, and issues lanes as read ports allow.
// Assumes the fetch side keeps a bundle presented until stall_o is low.
module vba_alloc
    import vba_pkg::*;
#(
    parameter int OPW      = 64,
    parameter int LITW     = 64,
    parameter int NLIT     = 2,
    parameter int AW       = 10,
    parameter int RD_PORTS = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bnd_valid_i,
    input  logic [CNTW-1:0]                     bnd_cnt_i,
    input  logic [NLANE-1:0][1:0]               bnd_cls_i,
    input  logic [NLANE-1:0][OPW-1:0]           bnd_op_i,
    input  logic [NLANE-1:0][NSRC-1:0][AW-1:0]  bnd_src_i,
    input  logic [NLANE-1:0][NSRC-1:0]          bnd_srcv_i,
    input  logic [NLIT-1:0][LITW-1:0]           bnd_lit_i,
    input  logic                                alu_rdy_i,
    output logic                                stall_o,
    output logic                                err_o,
    output logic [NLANE-1:0]                    lane_issue_o,
    output logic [NLANE-1:0][OPW-1:0]           lane_op_o,
    output logic [NLANE-1:0][NSRC-1:0][AW-1:0]  lane_src_o,
    output logic [NLANE-1:0][NSRC-1:0]          lane_srcv_o,
    output logic [NLIT-1:0][LITW-1:0]           lane_lit_o
);
    logic                                map_bad;
    logic [NLANE-1:0]                    map_mask;
    logic [NLANE-1:0][OPW-1:0]           map_op;
    logic [NLANE-1:0][NSRC-1:0][AW-1:0]  map_src;
    logic [NLANE-1:0][NSRC-1:0]          map_srcv;

    logic [NLANE-1:0]                    pend_q;
    logic [NLANE-1:0][OPW-1:0]           lane_op_q;
    logic [NLANE-1:0][NSRC-1:0][AW-1:0]  lane_src_q;
    logic [NLANE-1:0][NSRC-1:0]          lane_srcv_q;
    logic [NLIT-1:0][LITW-1:0]           lit_q;
    logic                                err_q;
    logic [NLANE-1:0]                    grant;
    logic                                accept;

    vba_slot_map #(.OPW(OPW), .AW(AW)) u_map (
        .cnt_i  (bnd_cnt_i),
        .cls_i  (bnd_cls_i),
        .op_i   (bnd_op_i),
        .src_i  (bnd_src_i),
        .srcv_i (bnd_srcv_i),
        .bad_o  (map_bad),
        .mask_o (map_mask),
        .op_o   (map_op),
        .src_o  (map_src),
        .srcv_o (map_srcv)
    );

    vba_port_arb #(.AW(AW), .RD_PORTS(RD_PORTS)) u_arb (
        .rdy_i   (alu_rdy_i),
        .pend_i  (pend_q),
        .src_i   (lane_src_q),
        .srcv_i  (lane_srcv_q),
        .grant_o (grant)
    );

    // Stall while some held lane survives this cycle; accept only otherwise.
    always_comb begin
        stall_o = |(pend_q & ~grant);
        accept  = bnd_valid_i && !stall_o;
    end

    // Retire granted lanes and load the next bundle or flag a dropped one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= '0;
            err_q       <= 1'b0;
            lane_op_q   <= '0;
            lane_src_q  <= '0;
            lane_srcv_q <= '0;
            lit_q       <= '0;
        end else begin
            err_q  <= 1'b0;
            pend_q <= pend_q & ~grant;
            if (accept) begin
                if (map_bad) begin
                    err_q  <= 1'b1;
                    pend_q <= '0;
                end else begin
                    pend_q      <= map_mask;
                    lane_op_q   <= map_op;
                    lane_src_q  <= map_src;
                    lane_srcv_q <= map_srcv;
                    lit_q       <= bnd_lit_i;
                end
            end
        end
    end

    // Drive the lane-facing outputs from the held bundle.
    always_comb begin
        lane_issue_o = grant;
        lane_op_o    = lane_op_q;
        lane_src_o   = lane_src_q;
        lane_srcv_o  = lane_srcv_q;
        lane_lit_o   = lit_q;
        err_o        = err_q;
    end

    // R10
    unready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_rdy_i |-> lane_issue_o == '0);

    // R9
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> $stable(lane_op_q) && $stable(lit_q) && $stable(lane_src_q));

    // R9
    issue_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_issue_o & ~pend_q) == '0);

    // R5
    dropped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (lane_issue_o == '0 && !stall_o));

    // R2
    lane_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !map_bad) |=> $countones(pend_q) == int'($past(bnd_cnt_i)));
endmodule

// File: tb/tb_vba_alloc.sv
module tb_vba_alloc;
    import vba_pkg::*;
    localparam int OPW = 64, LITW = 64, NLIT = 2, AW = 10, RDP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                                bnd_valid;
    logic [CNTW-1:0]                     bnd_cnt;
    logic [NLANE-1:0][1:0]               bnd_cls;
    logic [NLANE-1:0][OPW-1:0]           bnd_op;
    logic [NLANE-1:0][NSRC-1:0][AW-1:0]  bnd_src;
    logic [NLANE-1:0][NSRC-1:0]          bnd_srcv;
    logic [NLIT-1:0][LITW-1:0]           bnd_lit;
    logic                                alu_rdy;
    logic                                stall, err;
    logic [NLANE-1:0]                    lane_issue;
    logic [NLANE-1:0][OPW-1:0]           lane_op;
    logic [NLANE-1:0][NSRC-1:0][AW-1:0]  lane_src;
    logic [NLANE-1:0][NSRC-1:0]          lane_srcv;
    logic [NLIT-1:0][LITW-1:0]           lane_lit;

    vba_alloc #(.OPW(OPW), .LITW(LITW), .NLIT(NLIT), .AW(AW), .RD_PORTS(RDP)) dut (
        .clk(clk), .rst_n(rst_n), .bnd_valid_i(bnd_valid), .bnd_cnt_i(bnd_cnt),
        .bnd_cls_i(bnd_cls), .bnd_op_i(bnd_op), .bnd_src_i(bnd_src), .bnd_srcv_i(bnd_srcv),
        .bnd_lit_i(bnd_lit), .alu_rdy_i(alu_rdy), .stall_o(stall), .err_o(err),
        .lane_issue_o(lane_issue), .lane_op_o(lane_op), .lane_src_o(lane_src),
        .lane_srcv_o(lane_srcv), .lane_lit_o(lane_lit)
    );

    int checks = 0, errors = 0, opseq = 1;
    bit done = 0;

    // reference model state
    logic [NLANE-1:0]          m_pend;
    logic                      m_err;
    logic [OPW-1:0]            m_op  [NLANE];
    int                        m_src [NLANE][NSRC];
    bit                        m_sv  [NLANE][NSRC];
    logic [NLIT-1:0][LITW-1:0] m_lit;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit in_q(int q[$], int a);
        foreach (q[k]) if (q[k] == a) return 1;
        return 0;
    endfunction

    // Model arbitration: lanes in order, a set of addresses already being read.
    function automatic logic [NLANE-1:0] model_grant();
        int taken[$];
        int budget = RDP;
        logic [NLANE-1:0] g = '0;
        if (!alu_rdy) return '0;
        for (int l = 0; l < NLANE; l++) begin
            int fresh[$];
            if (!m_pend[l]) continue;
            for (int s = 0; s < NSRC; s++)
                if (m_sv[l][s] && !in_q(taken, m_src[l][s]) && !in_q(fresh, m_src[l][s]))
                    fresh.push_back(m_src[l][s]);
            if (fresh.size() <= budget) begin
                g[l] = 1'b1;
                budget -= fresh.size();
                foreach (fresh[k]) taken.push_back(fresh[k]);
            end
        end
        return g;
    endfunction

    task automatic model_load(int lane, int slot);
        m_op[lane] = bnd_op[slot];
        for (int s = 0; s < NSRC; s++) begin
            m_src[lane][s] = int'(bnd_src[slot][s]);
            m_sv[lane][s]  = bnd_srcv[slot][s];
        end
        m_pend[lane] = 1'b1;
    endtask

    // Model acceptance: queue of general-capable slots, special slot apart.
    task automatic model_accept();
        int order[$];
        int spec_slot = -1, n_spec = 0, n_gen = 0;
        bit bad = (bnd_cnt == 0) || (int'(bnd_cnt) > NLANE);
        for (int i = 0; i < NLANE && i < int'(bnd_cnt); i++) begin
            if (bnd_cls[i] == 2'b11) bad = 1;
            if (bnd_cls[i] == 2'b01) begin n_spec++; spec_slot = i; end
            if (bnd_cls[i] == 2'b10) begin n_gen++; order.push_back(i); end
        end
        for (int i = 0; i < NLANE && i < int'(bnd_cnt); i++)
            if (bnd_cls[i] == 2'b00) order.push_back(i);
        if (n_spec > 1 || n_gen > NGEN) bad = 1;
        m_err  = bad;
        m_pend = '0;
        if (!bad) begin
            foreach (order[k]) model_load((k < NGEN) ? k : SPEC, order[k]);
            if (spec_slot >= 0) model_load(SPEC, spec_slot);
            m_lit = bnd_lit;
        end
    endtask

    // One clock: compare outputs against the model, then advance both.
    task automatic step(string tag);
        logic [NLANE-1:0] g;
        logic exp_stall;
        #1;
        g = model_grant();
        exp_stall = |(m_pend & ~g);
        check(tag, "issue", 128'(lane_issue), 128'(g));
        check(tag, "stall", 128'(stall), 128'(exp_stall));
        check(tag, "err", 128'(err), 128'(m_err));
        for (int l = 0; l < NLANE; l++) begin
            if (g[l]) begin
                check(tag, "op", 128'(lane_op[l]), 128'(m_op[l]));
                for (int s = 0; s < NSRC; s++) begin
                    check(tag, "srcv", 128'(lane_srcv[l][s]), 128'(m_sv[l][s]));
                    if (m_sv[l][s]) check(tag, "src", 128'(lane_src[l][s]), 128'(m_src[l][s]));
                end
            end
        end
        if (|g) check(tag, "lit", 128'(lane_lit), 128'(m_lit));
        m_pend = m_pend & ~g;
        m_err  = 1'b0;
        if (bnd_valid && !exp_stall) model_accept();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic new_bundle(int cnt);
        bnd_cnt  = CNTW'(cnt);
        bnd_cls  = '0;
        bnd_op   = '0;
        bnd_src  = '0;
        bnd_srcv = '0;
        bnd_lit[0] = {32'h1111_0000, 32'(opseq)};
        bnd_lit[1] = {32'h2222_0000, 32'(opseq * 7)};
    endtask

    task automatic put(int i, logic [1:0] c, int a0, int a1, int a2, logic [2:0] v);
        bnd_cls[i]    = c;
        bnd_op[i]     = {16'hA5A5, 16'(i), 32'(opseq)};
        opseq++;
        bnd_src[i][0] = AW'(a0);
        bnd_src[i][1] = AW'(a1);
        bnd_src[i][2] = AW'(a2);
        bnd_srcv[i]   = v;
    endtask

    task automatic drain(string tag);
        for (int k = 0; k < 12 && (m_pend != '0 || m_err); k++) step(tag);
        step(tag);
    endtask

    task automatic send(string tag);
        bnd_valid = 1'b1;
        step(tag);
        bnd_valid = 1'b0;
        drain(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        bnd_valid = 1'b0;
        alu_rdy   = 1'b1;
        new_bundle(0);
        m_pend = '0;
        m_err  = 1'b0;
        m_lit  = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        check("R1", "issue in reset", 128'(lane_issue), 128'(0));
        check("R1", "stall in reset", 128'(stall), 128'(0));
        rst_n = 1'b1;
        repeat (3) step("R1");

        // R2: three generic ops on lanes 0..2
        new_bundle(3);
        put(0, 2'b00, 1, 2, 3, 3'b111);
        put(1, 2'b00, 4, 5, 0, 3'b011);
        put(2, 2'b00, 6, 0, 0, 3'b001);
        send("R2");
        // R2: five generic ops, the fifth spills to lane 4
        new_bundle(5);
        for (int i = 0; i < 5; i++) put(i, 2'b00, 10 + i, 0, 0, 3'b001);
        send("R2");

        // R3: special op in slot 0 goes to lane 4
        new_bundle(3);
        put(0, 2'b01, 20, 0, 0, 3'b001);
        put(1, 2'b00, 21, 0, 0, 3'b001);
        put(2, 2'b00, 22, 0, 0, 3'b001);
        send("R3");

        // R4: three dot components placed ahead of two generic ops
        new_bundle(5);
        put(0, 2'b00, 30, 0, 0, 3'b001);
        put(1, 2'b00, 31, 0, 0, 3'b001);
        put(2, 2'b10, 32, 0, 0, 3'b001);
        put(3, 2'b10, 33, 0, 0, 3'b001);
        put(4, 2'b10, 34, 0, 0, 3'b001);
        send("R4");

        // R5: illegal bundles are dropped
        new_bundle(0);
        send("R5");
        new_bundle(6);
        for (int i = 0; i < 5; i++) put(i, 2'b00, 1, 0, 0, 3'b001);
        send("R5");
        new_bundle(2);
        put(0, 2'b01, 1, 0, 0, 3'b001);
        put(1, 2'b01, 2, 0, 0, 3'b001);
        send("R5");
        new_bundle(2);
        put(0, 2'b00, 1, 0, 0, 3'b001);
        put(1, 2'b11, 2, 0, 0, 3'b001);
        send("R5");
        new_bundle(5);
        for (int i = 0; i < 5; i++) put(i, 2'b10, 3 + i, 0, 0, 3'b001);
        send("R5");

        // R6: shared addresses merge into one port each
        new_bundle(5);
        for (int i = 0; i < 5; i++) put(i, 2'b00, 60, 61, 62, 3'b111);
        send("R6");
        new_bundle(4);
        put(0, 2'b00, 70, 71, 72, 3'b111);
        put(1, 2'b00, 73, 74, 75, 3'b111);
        put(2, 2'b00, 76, 77, 76, 3'b111);
        put(3, 2'b00, 70, 0, 0, 3'b001);
        send("R6");
        new_bundle(4);
        for (int i = 0; i < 4; i++) put(i, 2'b00, 40 + 3 * i, 41 + 3 * i, 42 + 3 * i, 3'b111);
        send("R6");

        // R7: lane 2 does not fit, lane 3 still issues
        new_bundle(4);
        put(0, 2'b00, 80, 81, 82, 3'b111);
        put(1, 2'b00, 83, 84, 85, 3'b111);
        put(2, 2'b00, 86, 87, 88, 3'b111);
        put(3, 2'b00, 89, 0, 0, 3'b001);
        send("R7");

        // R8: special lane reads for free through a shared address
        new_bundle(5);
        put(0, 2'b01, 90, 0, 0, 3'b001);
        put(1, 2'b00, 90, 91, 92, 3'b111);
        put(2, 2'b00, 93, 94, 95, 3'b111);
        put(3, 2'b00, 96, 97, 0, 3'b011);
        put(4, 2'b00, 98, 0, 0, 3'b001);
        send("R8");
        // R8: special lane without a shared address waits for spare ports
        new_bundle(5);
        put(0, 2'b01, 99, 0, 0, 3'b001);
        put(1, 2'b00, 90, 91, 92, 3'b111);
        put(2, 2'b00, 93, 94, 95, 3'b111);
        put(3, 2'b00, 96, 97, 0, 3'b011);
        put(4, 2'b00, 98, 0, 0, 3'b001);
        send("R8");

        // R9: a bundle presented during a stall is ignored until stall falls
        new_bundle(4);
        for (int i = 0; i < 4; i++) put(i, 2'b00, 100 + 3 * i, 101 + 3 * i, 102 + 3 * i, 3'b111);
        bnd_valid = 1'b1;
        step("R9");
        new_bundle(2);
        put(0, 2'b00, 200, 0, 0, 3'b001);
        put(1, 2'b01, 201, 0, 0, 3'b001);
        step("R9");
        step("R9");
        bnd_valid = 1'b0;
        drain("R9");

        // R10: ALU not ready holds everything
        new_bundle(3);
        put(0, 2'b00, 210, 0, 0, 3'b001);
        put(1, 2'b10, 211, 0, 0, 3'b001);
        put(2, 2'b01, 212, 0, 0, 3'b001);
        bnd_valid = 1'b1;
        step("R10");
        bnd_valid = 1'b0;
        alu_rdy = 1'b0;
        repeat (3) step("R10");
        alu_rdy = 1'b1;
        drain("R10");

        // R11: distinct literals travel with the issued lanes
        new_bundle(2);
        put(0, 2'b00, 220, 221, 0, 3'b011);
        put(1, 2'b01, 222, 0, 0, 3'b001);
        bnd_lit[0] = 64'hDEAD_BEEF_0123_4567;
        bnd_lit[1] = 64'h89AB_CDEF_FEDC_BA98;
        send("R11");

        // R12: back-to-back bundles with no gap
        bnd_valid = 1'b1;
        for (int b = 0; b < 6; b++) begin
            new_bundle(1 + (b % 5));
            for (int i = 0; i < 1 + (b % 5); i++) put(i, 2'b00, 300 + 2 * b + i, 0, 0, 3'b001);
            step("R12");
        end
        bnd_valid = 1'b0;
        drain("R12");

        finish_run();
    end
endmodule